// File: doc/BRIEF.md
# Receiver Modem Control Pin Logic

This block sits beside a serial channel's receiver and handles the modem control pins tied to it. It brings the general-purpose sync pin and the carrier-detect pin into the clock domain and reports them as status bits. It also decides whether the sync pin is driven by the chip or read as an input. It drives the active-low DTR/request pin from either a control bit or a DMA request.

It also provides an automatic receive enable. With this mode on, a high level on the carrier-detect pin holds the receiver off, even when software has set the receive enable. The serial datapath is not part of this block. The value driven onto the sync pin comes from outside. This block supplies only that pin's output enable.

Top module: `rx_modem_ctl`

## Requirements
- R1: In asynchronous mode (`chan_mode_i`=0) with `xtal_en`=0, `sync_stat` equals the level of `sync_pin_i`. A change on the pin reaches `sync_stat` after two rising clock edges.
- R2: When `xtal_en`=1, `sync_stat` is 0 whatever the pin level and mode.
- R3: In synchronous mode (`chan_mode_i`=1) with `ext_sync_en`=0 and `xtal_en`=0, `sync_pin_oe` is 1 and `sync_stat` is 0. With `ext_sync_en`=1, `sync_pin_oe` is 0 and `sync_stat` follows the pin as in R1.
- R4: In asynchronous mode, or while `xtal_en`=1, `sync_pin_oe` is 0.
- R5: With `req_sel`=0, `dtr_req_n` is the inverse of `dtr_bit`, registered once. It changes one rising edge after `dtr_bit` changes.
- R6: With `req_sel`=1, `dtr_req_n` is the inverse of `dma_req`, registered once, and `dtr_bit` has no effect on the pin.
- R7: `dcd_stat` equals the level of `dcd_pin_i` in every mode, with the same two-edge latency as R1.
- R8: With `auto_en`=0, `rx_en_eff` equals `rx_en`, and the carrier-detect level has no effect.
- R9: With `auto_en`=1 and `rx_en`=1, `rx_en_eff` is 1 while the synchronized carrier-detect level is low, and 0 while it is high.
- R10: With `rx_en`=0, `rx_en_eff` is 0 whatever `auto_en` and the carrier-detect pin do.
- R11: While `rst_n` is low, `dtr_req_n` is 1 and both synchronizer stages hold 1. After reset, in asynchronous mode with `xtal_en`=0, `sync_stat` and `dcd_stat` read 1 and `rx_en_eff` follows R8/R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_pin_i | input | 1 | Sync pin level (asynchronous to clk) |
| dcd_pin_i | input | 1 | Carrier-detect pin level (asynchronous to clk) |
| chan_mode_i | input | 1 | 0 = asynchronous, 1 = synchronous/bit-oriented |
| ext_sync_en | input | 1 | External sync selected in synchronous mode |
| xtal_en | input | 1 | Crystal oscillator occupies the sync pin |
| dtr_bit | input | 1 | DTR control bit |
| req_sel | input | 1 | DTR/request pin carries DMA request |
| dma_req | input | 1 | DMA request, active high |
| auto_en | input | 1 | Carrier-detect gating of the receiver |
| rx_en | input | 1 | Software receive enable |
| sync_stat | output | 1 | Sync/hunt status bit |
| dcd_stat | output | 1 | Carrier-detect status bit |
| sync_pin_oe | output | 1 | Output enable for the sync pin |
| dtr_req_n | output | 1 | Active-low DTR/request pin drive |
| rx_en_eff | output | 1 | Effective receiver enable |

## Verification
The hardest case to reach is a carrier-detect edge that arrives while auto-enable and receive enable are both already set. In that case `rx_en_eff` must follow the pin exactly two edges later and not earlier. The bench sets the control bits first and then toggles the pin on a falling edge. It samples `rx_en_eff` after one rising edge, where it must still hold the old value, and again after the second, where it must hold the new value. The same two-point sampling confirms the synchronizer latency on the sync pin.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } chan_mode_e;

  // Receiver allowed when enabled and not blocked by a high carrier level
  function automatic logic rx_gate(input logic en, input logic auto_on,
                                   input logic dcd_level);
    return en & ~(auto_on & dcd_level);
  endfunction

  // True when the sync pin is read as an input and reported
  function automatic logic sync_is_input(input chan_mode_e mode,
                                         input logic ext_sync,
                                         input logic xtal);
    if (xtal) return 1'b0;
    if (mode == MODE_ASYNC) return 1'b1;
    return ext_sync;
  endfunction

  // True when the chip drives the sync pin
  function automatic logic sync_is_output(input chan_mode_e mode,
                                          input logic ext_sync,
                                          input logic xtal);
    return (mode == MODE_SYNC) & ~ext_sync & ~xtal;
  endfunction

endpackage

// File: rtl/mdm_sync2.sv
module mdm_sync2 #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int LAST = STAGES - 1;

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [LAST:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
        else        chain_q <= {chain_q[LAST-1:0], d_i[b]};
      end
      assign q_o[b] = chain_q[LAST];
    end
  endgenerate

endmodule

// File: rtl/mdm_sync_pin_ctl.sv
module mdm_sync_pin_ctl
  import mdm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  chan_mode_e mode_i,
  input  logic       ext_sync_i,
  input  logic       xtal_i,
  input  logic       sync_lvl_i,
  output logic       sync_stat_o,
  output logic       sync_oe_o
);

  logic pin_read;
  assign pin_read    = sync_is_input(mode_i, ext_sync_i, xtal_i);
  assign sync_stat_o = pin_read & sync_lvl_i;
  assign sync_oe_o   = sync_is_output(mode_i, ext_sync_i, xtal_i);

  // R2
  xtal_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xtal_i |-> !sync_stat_o);

  // R4
  async_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_ASYNC || xtal_i) |-> !sync_oe_o);

endmodule

// File: rtl/mdm_dtr_drv.sv
module mdm_dtr_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic dtr_bit_i,
  input  logic req_sel_i,
  input  logic dma_req_i,
  output logic pin_n_o
);

  logic level_d;
  assign level_d = req_sel_i ? dma_req_i : dtr_bit_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_n_o <= 1'b1;
    else        pin_n_o <= ~level_d;
  end

  // R6
  dma_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_sel_i |=> (pin_n_o == !$past(dma_req_i)));

endmodule

// File: rtl/mdm_rx_gate.sv
module mdm_rx_gate
  import mdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en_i,
  input  logic auto_i,
  input  logic dcd_lvl_i,
  output logic rx_eff_o
);

  assign rx_eff_o = rx_gate(rx_en_i, auto_i, dcd_lvl_i);

  // R10
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |-> !rx_eff_o);

  // R9
  carrier_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_i && dcd_lvl_i) |-> !rx_eff_o);

endmodule

// File: rtl/rx_modem_ctl.sv
module rx_modem_ctl
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_pin_i,
  input  logic dcd_pin_i,
  input  logic chan_mode_i,
  input  logic ext_sync_en,
  input  logic xtal_en,
  input  logic dtr_bit,
  input  logic req_sel,
  input  logic dma_req,
  input  logic auto_en,
  input  logic rx_en,
  output logic sync_stat,
  output logic dcd_stat,
  output logic sync_pin_oe,
  output logic dtr_req_n,
  output logic rx_en_eff
);

  localparam int NPINS   = 2;
  localparam int IDX_SYN = 0;
  localparam int IDX_DCD = 1;

  logic [NPINS-1:0] pins_raw, pins_lvl;
  chan_mode_e       mode;

  assign pins_raw[IDX_SYN] = sync_pin_i;
  assign pins_raw[IDX_DCD] = dcd_pin_i;
  assign mode = chan_mode_e'(chan_mode_i);

  mdm_sync2 #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_lvl)
  );

  mdm_sync_pin_ctl u_syncpin (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .ext_sync_i(ext_sync_en),
    .xtal_i(xtal_en), .sync_lvl_i(pins_lvl[IDX_SYN]),
    .sync_stat_o(sync_stat), .sync_oe_o(sync_pin_oe)
  );

  mdm_dtr_drv u_dtr (
    .clk(clk), .rst_n(rst_n), .dtr_bit_i(dtr_bit), .req_sel_i(req_sel),
    .dma_req_i(dma_req), .pin_n_o(dtr_req_n)
  );

  mdm_rx_gate u_gate (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .auto_i(auto_en),
    .dcd_lvl_i(pins_lvl[IDX_DCD]), .rx_eff_o(rx_en_eff)
  );

  assign dcd_stat = pins_lvl[IDX_DCD];

  // R8
  no_auto_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |-> (rx_en_eff == rx_en));

endmodule

// File: tb/rx_modem_ctl_tb.sv
module rx_modem_ctl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_pin_i = 1'b1, dcd_pin_i = 1'b1;
  logic chan_mode_i = 1'b0, ext_sync_en = 1'b0, xtal_en = 1'b0;
  logic dtr_bit = 1'b0, req_sel = 1'b0, dma_req = 1'b0;
  logic auto_en = 1'b0, rx_en = 1'b0;
  logic sync_stat, dcd_stat, sync_pin_oe, dtr_req_n, rx_en_eff;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  rx_modem_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .sync_pin_i(sync_pin_i), .dcd_pin_i(dcd_pin_i),
    .chan_mode_i(chan_mode_i), .ext_sync_en(ext_sync_en), .xtal_en(xtal_en),
    .dtr_bit(dtr_bit), .req_sel(req_sel), .dma_req(dma_req),
    .auto_en(auto_en), .rx_en(rx_en), .sync_stat(sync_stat),
    .dcd_stat(dcd_stat), .sync_pin_oe(sync_pin_oe), .dtr_req_n(dtr_req_n),
    .rx_en_eff(rx_en_eff)
  );

  function automatic logic model_eff(logic en, logic aut, logic dcd);
    if (!en) return 1'b0;
    if (aut && dcd) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_fall(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 dtr in reset", dtr_req_n, 1'b1);
    rst_n = 1'b1;
    wait_fall(1);
    check("R11 sync_stat", sync_stat, 1'b1);
    check("R11 dcd_stat", dcd_stat, 1'b1);
    check("R11 dtr", dtr_req_n, 1'b1);
    check("R11 rx_en_eff", rx_en_eff, 1'b0);
  endtask

  task automatic t_sync_async;
    chan_mode_i = 1'b0; xtal_en = 1'b0;
    sync_pin_i = 1'b0;
    wait_fall(1);
    check("R1 one edge still old", sync_stat, 1'b1);
    wait_fall(1);
    check("R1 two edges low", sync_stat, 1'b0);
    check("R4 async oe", sync_pin_oe, 1'b0);
    sync_pin_i = 1'b1;
    wait_fall(2);
    check("R1 high", sync_stat, 1'b1);
  endtask

  task automatic t_xtal;
    xtal_en = 1'b1;
    wait_fall(1);
    check("R2 xtal async", sync_stat, 1'b0);
    check("R4 xtal oe", sync_pin_oe, 1'b0);
    chan_mode_i = 1'b1; ext_sync_en = 1'b1;
    wait_fall(1);
    check("R2 xtal ext sync", sync_stat, 1'b0);
    check("R4 xtal sync oe", sync_pin_oe, 1'b0);
    xtal_en = 1'b0; ext_sync_en = 1'b0; chan_mode_i = 1'b0;
    wait_fall(1);
  endtask

  task automatic t_sync_mode;
    chan_mode_i = 1'b1; ext_sync_en = 1'b0;
    sync_pin_i = 1'b1;
    wait_fall(2);
    check("R3 sync oe", sync_pin_oe, 1'b1);
    check("R3 sync stat", sync_stat, 1'b0);
    ext_sync_en = 1'b1;
    wait_fall(1);
    check("R3 ext oe", sync_pin_oe, 1'b0);
    check("R3 ext stat high", sync_stat, 1'b1);
    sync_pin_i = 1'b0;
    wait_fall(2);
    check("R3 ext stat low", sync_stat, 1'b0);
    chan_mode_i = 1'b0; ext_sync_en = 1'b0; sync_pin_i = 1'b1;
    wait_fall(2);
  endtask

  task automatic t_dtr;
    req_sel = 1'b0;
    for (int i = 0; i < 2; i++) begin
      dtr_bit = (i == 0);
      dma_req = (i != 0);
      wait_fall(1);
      check("R5 dtr inverse", dtr_req_n, ~dtr_bit);
    end
    req_sel = 1'b1;
    for (int i = 0; i < 4; i++) begin
      dma_req = i[0];
      dtr_bit = i[1];
      wait_fall(1);
      check("R6 dma inverse", dtr_req_n, ~dma_req);
    end
    req_sel = 1'b0; dtr_bit = 1'b0;
    wait_fall(1);
    check("R5 back to dtr", dtr_req_n, 1'b1);
  endtask

  task automatic t_dcd_gate;
    rx_en = 1'b1; auto_en = 1'b0;
    dcd_pin_i = 1'b1;
    wait_fall(2);
    check("R7 dcd high", dcd_stat, 1'b1);
    check("R8 no auto high dcd", rx_en_eff, 1'b1);
    auto_en = 1'b1;
    wait_fall(1);
    check("R9 blocked", rx_en_eff, model_eff(1'b1, 1'b1, 1'b1));
    dcd_pin_i = 1'b0;
    wait_fall(1);
    check("R9 one edge still blocked", rx_en_eff, 1'b0);
    check("R7 one edge old", dcd_stat, 1'b1);
    wait_fall(1);
    check("R9 released", rx_en_eff, 1'b1);
    check("R7 dcd low", dcd_stat, 1'b0);
    rx_en = 1'b0;
    wait_fall(1);
    check("R10 off low dcd", rx_en_eff, 1'b0);
    auto_en = 1'b0;
    dcd_pin_i = 1'b1;
    wait_fall(2);
    check("R10 off no auto", rx_en_eff, 1'b0);
    rx_en = 1'b1;
    wait_fall(1);
    check("R8 follows rx_en", rx_en_eff, 1'b1);
    chan_mode_i = 1'b1;
    dcd_pin_i = 1'b0;
    wait_fall(2);
    check("R7 sync mode", dcd_stat, 1'b0);
    chan_mode_i = 1'b0;
  endtask

  initial begin
    wait_fall(3);
    t_reset();
    t_sync_async();
    t_xtal();
    t_sync_mode();
    t_dtr();
    t_dcd_gate();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule